// File: doc/BRIEF.md
# MDIO Management Interface Master

This block runs one management transaction at a time against a PHY's register file over the two-wire clock/data management link. A host raises `start` for one system clock. With it the host gives a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block then produces the management clock `mdc` from a divided system clock and serialises a complete frame. Every frame opens with a full-length preamble of ones. The data line leaves the block as a separate value `mdio_o` and enable `mdio_oe`, so that a pad or a board-level buffer can tri-state it. The returning line state arrives on `mdio_i`.

On reads the block lets go of the line for the turnaround and insists that the PHY pulls it low. If the PHY does not, the block gives up on the transfer. It clocks out a burst of idle cycles to bring the PHY back into step and then reports an error. Completion is signalled by a one-clock `done` pulse. The captured data and the error flag then hold until the host starts the next transaction.

Top module: `mdio_master`

## Requirements
- R1: Each transaction begins with PRE_BITS (default 32) MDC cycles during which `mdio_oe`=1 and `mdio_o`=1.
- R2: After the preamble, 14 driven bits follow, one per MDC cycle: start 0,1; then the opcode (1,0 for read, `rd_nwr`=1; 0,1 for write); then `phy_addr` MSB first; then `reg_addr` MSB first.
- R3: Each MDC low phase and each high phase lasts DIV system clocks. `mdio_o` changes only while `mdc` is low. Between transactions `mdc`=0 and `mdio_oe`=0.
- R4: On a read, `mdio_oe` is 0 from the turnaround onward. The turnaround bit (MDC cycle 46 from 0) is sampled at the end of its high phase and must be 0. The 16 data bits that follow are sampled the same way, MSB first. Two more released MDC cycles follow before done, and `rdata` then holds the word.
- R5: If the read turnaround sample is 1, the block gives RECOVER_BITS (default 32) further MDC cycles with `mdio_oe`=0. It then completes with `err`=1 and `rdata`=0.
- R6: On a write, the turnaround is driven as 1,0. `wdata` follows MSB first. Then comes one MDC cycle with `mdio_oe`=0 before done. A write leaves `rdata` unchanged.
- R7: A `start` pulse that arrives while `busy`=1 has no effect on the frame in flight and starts nothing afterwards.
- R8: `done` is high for exactly one system clock, in the first cycle with `busy`=0. `err` is cleared when a transaction is accepted. `rdata` and `err` stay stable while idle.
- R9: After reset, `mdc`, `mdio_oe`, `busy`, `done` and `err` are 0 and `rdata` is 0.
- R10: From the accepting clock edge to the edge that raises `done`, a read or write takes 2·DIV·65 system clocks. A failed read takes 2·DIV·79.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-clock request to begin a transaction |
| rd_nwr | input | 1 | 1 = read, 0 = write; sampled with start |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Data returned by the last successful read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Last transaction failed its turnaround check |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Sampled data line state |

## Verification
A model of the PHY records every line bit on each MDC rise. It answers reads with a chosen word, so the tests reach the bit ordering, the turnaround value, the direction of each phase and the exact frame length. A design that samples one cycle early or late returns a shifted word. One that skips the turnaround check, or the recovery burst, shows up as a wrong `err`, a wrong `rdata` or a frame of the wrong length. A start pulse injected mid-frame would show as a corrupted header or a second transaction if the block honoured it. The bench also confirms that a failed read clears `rdata`, that writes leave it alone and that the next start clears `err`.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV          = 4,
  parameter int PRE_BITS     = 32,
  parameter int RECOVER_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_nwr,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CMAX = (PRE_BITS > RECOVER_BITS) ? PRE_BITS : RECOVER_BITS;
  localparam int CW   = $clog2((CMAX < 32) ? 32 : CMAX) + 1;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SEND, S_TA, S_RDAT, S_TAIL} st_t;

  st_t            st;
  logic [DW-1:0]  divc;
  logic [CW-1:0]  cnt;
  logic [31:0]    sh;
  logic [15:0]    rx;
  logic           ph, rd, errq;
  logic           tick;

  assign busy    = (st != S_IDLE);
  assign tick    = busy && (divc == DW'(DIV - 1));
  assign mdc     = ph;
  assign mdio_oe = (st == S_PRE) || (st == S_SEND);
  assign mdio_o  = (st == S_SEND) ? sh[31] : (st == S_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           divc <= '0;
    else if (!busy || tick) divc <= '0;
    else                  divc <= divc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      sh    <= '0;
      rx    <= '0;
      ph    <= 1'b0;
      rd    <= 1'b0;
      errq  <= 1'b0;
      err   <= 1'b0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          st   <= S_PRE;
          cnt  <= CW'(PRE_BITS - 1);
          ph   <= 1'b0;
          rd   <= rd_nwr;
          sh   <= {2'b01, rd_nwr ? 2'b10 : 2'b01, phy_addr, reg_addr, 2'b10, wdata};
          err  <= 1'b0;
          errq <= 1'b0;
        end
      end else if (tick) begin
        if (!ph) begin
          ph <= 1'b1;
        end else begin
          ph <= 1'b0;
          case (st)
            S_PRE: begin
              if (cnt == '0) begin
                st  <= S_SEND;
                cnt <= rd ? CW'(13) : CW'(31);
              end else cnt <= cnt - 1'b1;
            end
            S_SEND: begin
              sh <= {sh[30:0], 1'b0};
              if (cnt == '0) begin
                if (rd) st <= S_TA;
                else begin
                  st  <= S_TAIL;
                  cnt <= '0;
                end
              end else cnt <= cnt - 1'b1;
            end
            S_TA: begin
              if (mdio_i) begin
                errq <= 1'b1;
                st   <= S_TAIL;
                cnt  <= CW'(RECOVER_BITS - 1);
              end else begin
                st  <= S_RDAT;
                cnt <= CW'(15);
              end
            end
            S_RDAT: begin
              rx <= {rx[14:0], mdio_i};
              if (cnt == '0) begin
                st  <= S_TAIL;
                cnt <= CW'(1);
              end else cnt <= cnt - 1'b1;
            end
            S_TAIL: begin
              if (cnt == '0) begin
                st   <= S_IDLE;
                done <= 1'b1;
                err  <= errq;
                if (rd) rdata <= errq ? 16'h0000 : rx;
              end else cnt <= cnt - 1'b1;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [15:0] rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  assert_data_moves_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> !mdc);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_err_clear_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !err);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(rdata) && $stable(err)));

  assert_busy_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_nwr = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        busy, done, err, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  mdio_master #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .done(done), .err(err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // rd, phy, reg, wdata, phy answer, bad turnaround
  localparam int NV = 6;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 5'h01, 5'h02, 16'h0000, 16'hA5C3, 1'b0},
    {1'b0, 5'h1F, 5'h00, 16'h8001, 16'h0000, 1'b0},
    {1'b1, 5'h10, 5'h1F, 16'h0000, 16'hFFFF, 1'b0},
    {1'b1, 5'h05, 5'h0A, 16'h0000, 16'h1234, 1'b1},
    {1'b0, 5'h00, 5'h15, 16'h3C5A, 16'h0000, 1'b0},
    {1'b1, 5'h1E, 5'h01, 16'h0000, 16'h0001, 1'b0}
  };

  logic        obs_oe [128];
  logic        obs_o  [128];
  int          k = 0;
  logic        m_rd = 1'b0;
  logic        m_tabad = 1'b0;
  logic [15:0] m_data = '0;
  logic [15:0] exp_rdata = '0;

  always @(posedge mdc) begin
    if (k < 128) begin
      obs_oe[k] = mdio_oe;
      obs_o[k]  = mdio_o;
    end
    if (m_rd && k == 46)                 mdio_i = m_tabad;
    else if (m_rd && k >= 47 && k <= 62) mdio_i = m_data[62 - k];
    else                                 mdio_i = 1'b1;
    k = k + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [43:0] v, input bit inject);
    logic        rd  = v[43];
    logic [4:0]  pa  = v[42:38];
    logic [4:0]  ra  = v[37:33];
    logic [15:0] wd  = v[32:17];
    logic [15:0] pd  = v[16:1];
    logic        tab = v[0];
    logic [13:0] hdr = {2'b01, rd ? 2'b10 : 2'b01, pa, ra};
    logic [17:0] wpay = {2'b10, wd};
    int nbits = (rd && tab) ? 79 : 65;
    int cyc = 0;
    int bad;
    k = 0; m_rd = rd; m_tabad = tab; m_data = pd;
    @(negedge clk);
    start = 1'b1; rd_nwr = rd; phy_addr = pa; reg_addr = ra; wdata = wd;
    @(negedge clk);
    start = 1'b0;
    check(busy && !err, "R8", "busy set, err cleared after accept", {busy, err}, 2'b10);
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (inject && cyc == 40) begin
        start = 1'b1; rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
      end else start = 1'b0;
      if (done || cyc > 4000) break;
    end
    start = 1'b0;
    check(cyc == 2 * DIV * nbits, "R10", "clocks to done", cyc, 2 * DIV * nbits);
    check(k == nbits, "R10", "MDC cycles", k, nbits);
    bad = 0;
    for (int i = 0; i < 32; i++) if (!(obs_oe[i] && obs_o[i])) bad++;
    check(bad == 0, "R1", "preamble bad bits", bad, 0);
    bad = 0;
    for (int i = 32; i < 46; i++) if (!obs_oe[i] || obs_o[i] != hdr[45 - i]) bad++;
    check(bad == 0, "R2", "header bad bits", bad, 0);
    bad = 0;
    if (rd) begin
      for (int i = 46; i < nbits && i < 128; i++) if (obs_oe[i]) bad++;
      check(bad == 0, tab ? "R5" : "R4", "driven bits after header", bad, 0);
      if (!tab) exp_rdata = pd; else exp_rdata = 16'h0000;
      check(err == tab, tab ? "R5" : "R4", "err", err, tab);
    end else begin
      for (int i = 46; i < 64; i++) if (!obs_oe[i] || obs_o[i] != wpay[63 - i]) bad++;
      if (obs_oe[64]) bad++;
      check(bad == 0, "R6", "turnaround/data/release bad bits", bad, 0);
      check(err == 1'b0, "R6", "err after write", err, 0);
    end
    check(rdata == exp_rdata, rd ? (tab ? "R5" : "R4") : "R6", "rdata", rdata, exp_rdata);
    @(negedge clk);
    check(!done && !busy, inject ? "R7" : "R8", "done one clock, no follow-on start",
          {done, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({mdc, mdio_oe, busy, done, err} == 5'b0 && rdata == 16'h0, "R9",
          "reset outputs", {mdc, mdio_oe, busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int n = 0; n < NV; n++) run(VEC[n], 1'b0);

    // start pulse mid-write must not disturb it (R7)
    run({1'b0, 5'h0A, 5'h11, 16'hBEEF, 16'h0000, 1'b0}, 1'b1);

    // failed read, then hold while idle, then next start clears err (R8)
    run({1'b1, 5'h03, 5'h04, 16'h0000, 16'hCAFE, 1'b1}, 1'b0);
    repeat (20) @(negedge clk);
    check(err && rdata == 16'h0 && !mdc && !mdio_oe, "R8", "idle hold after error",
          {err, rdata}, {1'b1, 16'h0});
    run({1'b1, 5'h03, 5'h04, 16'h0000, 16'h5A5A, 1'b0}, 1'b0);
    repeat (10) @(negedge clk);
    check(!err && rdata == 16'h5A5A, "R8", "err cleared, data held",
          {err, rdata}, {1'b0, 16'h5A5A});

    // half-period length (R3): mdc high lasts DIV clocks
    begin
      int hi = 0;
      k = 0; m_rd = 1'b0;
      @(negedge clk);
      start = 1'b1; rd_nwr = 1'b0;
      @(negedge clk);
      start = 1'b0;
      while (!mdc) @(negedge clk);
      while (mdc) begin hi++; @(negedge clk); end
      check(hi == DIV, "R3", "mdc high clocks", hi, DIV);
      while (busy) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule